// File: doc/BRIEF.md
# Oversampled Serial Receiver with Three-Entry Character Queue

This block receives asynchronous serial characters on one line. A one-cycle 16x oversampling tick paces it. It confirms each start bit at mid-bit and samples the data bits least significant first, one oversampling period apart. It then checks an optional even-parity bit and the stop bit. Each finished character and its own error flags go into a three-entry queue, so a CPU can read the data and the status of a character together.

When the queue is full, one more finished character is parked in the shift stage. A further arrival then raises a sticky overrun flag. A received break puts exactly one entry in the queue, and the receiver stays blocked until the line has been idle for half a bit. A one-cycle event marks both the start and the end of a break. Command strobes enable and disable the receiver and clear the overrun flag. The line input must already be synchronous to `clk_i`.

Top module: `uart_rx3`

## Requirements
- R1: The queue holds up to three characters in arrival order. `fifo_full_o` is 1 exactly while three entries are held.
- R2: A character that finishes while the queue is full waits in the shift stage and `overrun_o` stays 0. A read then moves it into the queue, so `fifo_full_o` stays 1 and the waiting character becomes the last entry.
- R3: `rx_rdy_o` is 1 while the queue holds at least one entry. A read (`rd_i` high for one cycle) removes the head. A read while the queue is empty has no effect.
- R4: If a character finishes while the queue is full and a character is already waiting, `overrun_o` is set. The waiting character is lost and the newest one waits in its place.
- R5: `overrun_o` stays set through reads and is cleared only by `cmd_rst_err_i`.
- R6: A low line seen on a tick starts a start-bit check. If the line is high at the eighth tick after that, the receiver goes back to searching and stores nothing.
- R7: Data bits are sampled least significant first, 16 ticks apart, beginning 16 ticks after the start-bit check. The stop bit is sampled at its middle, and a low sample sets `head_ferr_o` for that character.
- R8: When `par_en_i` is 1, one parity bit follows the data. The character's `head_perr_o` is set when the data bits plus the parity bit hold an odd number of ones. When `par_en_i` is 0, no parity bit is expected and `head_perr_o` is 0.
- R9: An all-zero character (parity bit 0 too, if enabled) with a low stop bit is a break. It is stored as one entry with `head_brk_o`=1, `head_ferr_o`=1 and data 0. No further entry is made until the line has been high for 8 consecutive ticks.
- R10: `brk_chg_o` pulses for one cycle when a break is detected and again when its end is detected.
- R11: Out of reset the receiver is disabled. `cmd_dis_i` stops it at once, drops any partial character and changes no status or queue content. A disabled receiver stores nothing.
- R12: `cmd_en_i` puts the receiver into the search-for-start state. If both commands come in the same cycle, disable wins.
- R13: After reset, `rx_rdy_o`, `fifo_full_o`, `overrun_o` and `brk_chg_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial line, idle high, synchronous to clk_i |
| tick_i | input | 1 | One-cycle 16x oversampling tick |
| rd_i | input | 1 | CPU read strobe, pops the queue head |
| cmd_en_i | input | 1 | Enable-receiver command strobe |
| cmd_dis_i | input | 1 | Disable-receiver command strobe |
| cmd_rst_err_i | input | 1 | Clear-overrun command strobe |
| par_en_i | input | 1 | Expect an even-parity bit after the data |
| rdata_o | output | 8 | Data of the head entry (0 when empty) |
| head_ferr_o | output | 1 | Framing error of the head entry |
| head_perr_o | output | 1 | Parity error of the head entry |
| head_brk_o | output | 1 | Head entry is a break |
| rx_rdy_o | output | 1 | Queue is not empty |
| fifo_full_o | output | 1 | Queue holds three entries |
| overrun_o | output | 1 | Sticky overrun flag |
| brk_chg_o | output | 1 | One-cycle change-in-break event |

## Verification
The hardest case to reach is the overrun path. It needs three queued characters plus a parked fourth, and then a fifth that arrives before any read. The stimulus sends five back-to-back frames with no reads, then drains the queue and checks that the fourth character is the one missing. Break handling needs the line held low well beyond one frame, plus a short high glitch that must not end the break. The bench counts `brk_chg_o` pulses across that whole stretch.

// File: rtl/uart_rx3_pkg.sv
package uart_rx3_pkg;
  parameter int CHAR_W = 8;

  typedef struct packed {
    logic              brk;
    logic              ferr;
    logic              perr;
    logic [CHAR_W-1:0] data;
  } rx_entry_t;
endpackage

// File: rtl/uart_rx3_shifter.sv
module uart_rx3_shifter
  import uart_rx3_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  logic      rx_i,
  input  logic      en_cmd_i,
  input  logic      dis_cmd_i,
  input  logic      par_en_i,
  output logic      done_o,
  output rx_entry_t entry_o,
  output logic      brk_evt_o
);
  localparam int CNT_W = $clog2(OSR);
  localparam int HALF  = OSR / 2;
  localparam int BIT_W = (CHAR_W > 1) ? $clog2(CHAR_W) : 1;

  typedef enum logic [2:0] {
    ST_OFF, ST_HUNT, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_BRKWAIT
  } rx_state_e;

  rx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [CHAR_W-1:0] shreg_q, shreg_d;
  logic              par_q, par_d;

  logic full_per, half_per, brk_hit;

  assign full_per = (cnt_q == CNT_W'(OSR - 1));
  assign half_per = (cnt_q == CNT_W'(HALF - 1));
  assign brk_hit  = !rx_i && (shreg_q == '0) && !(par_en_i && par_q);

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    bit_d     = bit_q;
    shreg_d   = shreg_q;
    par_d     = par_q;
    done_o    = 1'b0;
    brk_evt_o = 1'b0;
    entry_o.data = shreg_q;
    entry_o.ferr = !rx_i;
    entry_o.perr = par_en_i && (^{shreg_q, par_q});
    entry_o.brk  = brk_hit;
    if (dis_cmd_i) begin
      state_d = ST_OFF;
    end else if (en_cmd_i) begin
      state_d = ST_HUNT;
      cnt_d   = '0;
    end else if (tick_i) begin
      unique case (state_q)
        ST_HUNT: begin
          if (!rx_i) begin
            state_d = ST_START;
            cnt_d   = '0;
          end
        end
        ST_START: begin
          if (half_per) begin
            cnt_d   = '0;
            bit_d   = '0;
            state_d = rx_i ? ST_HUNT : ST_DATA;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_DATA: begin
          if (full_per) begin
            cnt_d   = '0;
            shreg_d = {rx_i, shreg_q[CHAR_W-1:1]};
            if (bit_q == BIT_W'(CHAR_W - 1)) begin
              state_d = par_en_i ? ST_PAR : ST_STOP;
            end else begin
              bit_d = bit_q + 1'b1;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_PAR: begin
          if (full_per) begin
            cnt_d   = '0;
            par_d   = rx_i;
            state_d = ST_STOP;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_STOP: begin
          if (full_per) begin
            cnt_d  = '0;
            done_o = 1'b1;
            if (brk_hit) begin
              brk_evt_o = 1'b1;
              state_d   = ST_BRKWAIT;
            end else begin
              state_d = ST_HUNT;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_BRKWAIT: begin
          if (!rx_i) begin
            cnt_d = '0;
          end else if (half_per) begin
            cnt_d     = '0;
            brk_evt_o = 1'b1;
            state_d   = ST_HUNT;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      cnt_q   <= '0;
      bit_q   <= '0;
      shreg_q <= '0;
      par_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      shreg_q <= shreg_d;
      par_q   <= par_d;
    end
  end
endmodule

// File: rtl/uart_rx3_fifo.sv
module uart_rx3_fifo #(
  parameter int  DEPTH = 3,
  parameter type entry_t = logic,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   push_i,
  input  entry_t push_data_i,
  input  logic   pop_i,
  output entry_t head_o,
  output logic   empty_o,
  output logic   full_o
);
  entry_t           mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign head_o  = mem_q[rd_q];

  always_comb begin
    wr_d  = push_i ? bump(wr_q) : wr_q;
    rd_d  = pop_i  ? bump(rd_q) : rd_q;
    cnt_d = cnt_q;
    if (push_i && !pop_i) cnt_d = cnt_q + 1'b1;
    if (pop_i && !push_i) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/uart_rx3.sv
module uart_rx3
  import uart_rx3_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int DEPTH = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic              tick_i,
  input  logic              rd_i,
  input  logic              cmd_en_i,
  input  logic              cmd_dis_i,
  input  logic              cmd_rst_err_i,
  input  logic              par_en_i,
  output logic [CHAR_W-1:0] rdata_o,
  output logic              head_ferr_o,
  output logic              head_perr_o,
  output logic              head_brk_o,
  output logic              rx_rdy_o,
  output logic              fifo_full_o,
  output logic              overrun_o,
  output logic              brk_chg_o
);
  logic      shift_done, brk_evt;
  rx_entry_t shift_entry;

  rx_entry_t hold_q, hold_d;
  logic      hold_vld_q, hold_vld_d;
  logic      ovr_q, ovr_d;
  logic      brk_chg_q;

  logic      q_push, q_pop, q_empty, q_full;
  rx_entry_t q_wdata, q_head;

  uart_rx3_shifter #(.OSR(OSR)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .rx_i     (rx_i),
    .en_cmd_i (cmd_en_i),
    .dis_cmd_i(cmd_dis_i),
    .par_en_i (par_en_i),
    .done_o   (shift_done),
    .entry_o  (shift_entry),
    .brk_evt_o(brk_evt)
  );

  uart_rx3_fifo #(.DEPTH(DEPTH), .entry_t(rx_entry_t)) u_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (q_push),
    .push_data_i(q_wdata),
    .pop_i      (q_pop),
    .head_o     (q_head),
    .empty_o    (q_empty),
    .full_o     (q_full)
  );

  // Queue intake: a parked character has priority over a new arrival.
  always_comb begin
    q_pop      = rd_i && !q_empty;
    q_push     = 1'b0;
    q_wdata    = shift_entry;
    hold_d     = hold_q;
    hold_vld_d = hold_vld_q;
    ovr_d      = cmd_rst_err_i ? 1'b0 : ovr_q;
    if (q_pop && hold_vld_q) begin
      q_push     = 1'b1;
      q_wdata    = hold_q;
      hold_vld_d = shift_done;
      if (shift_done) hold_d = shift_entry;
    end else if (shift_done) begin
      if (!q_full || q_pop) begin
        q_push = 1'b1;
      end else begin
        hold_d     = shift_entry;
        hold_vld_d = 1'b1;
        if (hold_vld_q) ovr_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q     <= '0;
      hold_vld_q <= 1'b0;
      ovr_q      <= 1'b0;
      brk_chg_q  <= 1'b0;
    end else begin
      hold_q     <= hold_d;
      hold_vld_q <= hold_vld_d;
      ovr_q      <= ovr_d;
      brk_chg_q  <= brk_evt;
    end
  end

  assign rx_rdy_o    = !q_empty;
  assign fifo_full_o = q_full;
  assign overrun_o   = ovr_q;
  assign brk_chg_o   = brk_chg_q;
  assign rdata_o     = q_empty ? '0 : q_head.data;
  assign head_ferr_o = !q_empty && q_head.ferr;
  assign head_perr_o = !q_empty && q_head.perr;
  assign head_brk_o  = !q_empty && q_head.brk;
endmodule

// File: rtl/uart_rx3_chk.sv
module uart_rx3_chk
  import uart_rx3_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_i,
  input logic              cmd_dis_i,
  input logic              cmd_rst_err_i,
  input logic              rx_rdy_o,
  input logic              fifo_full_o,
  input logic              overrun_o,
  input logic              head_brk_o,
  input logic              head_ferr_o,
  input logic [CHAR_W-1:0] rdata_o,
  input logic              hold_vld,
  input logic              done
);
  AST_FULL_HAS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_full_o |-> rx_rdy_o); // R1
  AST_PARKED_ONLY_WHEN_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_vld |-> fifo_full_o); // R2
  AST_READ_REFILLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_full_o && hold_vld && rd_i) |=> fifo_full_o); // R2
  AST_READY_PERSISTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_rdy_o && !rd_i) |=> rx_rdy_o); // R3
  AST_OVERRUN_NEEDS_PARKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> $past(hold_vld)); // R4
  AST_OVERRUN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && !cmd_rst_err_i) |=> overrun_o); // R5
  AST_BREAK_ENTRY_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_rdy_o && head_brk_o) |-> (head_ferr_o && rdata_o == '0)); // R9
  AST_DISABLE_SILENCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_dis_i |=> !done); // R11
endmodule

bind uart_rx3 uart_rx3_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rd_i         (rd_i),
  .cmd_dis_i    (cmd_dis_i),
  .cmd_rst_err_i(cmd_rst_err_i),
  .rx_rdy_o     (rx_rdy_o),
  .fifo_full_o  (fifo_full_o),
  .overrun_o    (overrun_o),
  .head_brk_o   (head_brk_o),
  .head_ferr_o  (head_ferr_o),
  .rdata_o      (rdata_o),
  .hold_vld     (hold_vld_q),
  .done         (shift_done)
);

// File: tb/uart_rx3_bench.sv
`timescale 1ns/1ps
module uart_rx3_bench;
  localparam int TICK_DIV = 4;
  localparam int BIT_CLK  = 16 * TICK_DIV;

  logic clk, rst_n, rx, tick, rd, c_en, c_dis, c_rerr, par_en;
  logic [7:0] rdata;
  logic ferr, perr, brk, rdy, full, ovr, bchg;

  int n_chk  = 0;
  int n_fail = 0;
  int brk_pulses = 0;

  uart_rx3 u_uart_rx3 (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .tick_i(tick), .rd_i(rd),
    .cmd_en_i(c_en), .cmd_dis_i(c_dis), .cmd_rst_err_i(c_rerr), .par_en_i(par_en),
    .rdata_o(rdata), .head_ferr_o(ferr), .head_perr_o(perr), .head_brk_o(brk),
    .rx_rdy_o(rdy), .fifo_full_o(full), .overrun_o(ovr), .brk_chg_o(bchg)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial begin
    int t;
    t = 0;
    tick = 1'b0;
    forever begin
      @(negedge clk);
      tick = (t == 0);
      t = (t == TICK_DIV - 1) ? 0 : t + 1;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (bchg) brk_pulses++;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic bit_out(input logic v);
    rx = v;
    repeat (BIT_CLK) @(negedge clk);
  endtask

  // pmode: 0 no parity bit, 1 correct even parity, 2 wrong parity
  task automatic send_char(input logic [7:0] d, input int pmode, input logic stop_v);
    bit_out(1'b0);
    for (int i = 0; i < 8; i++) bit_out(d[i]);
    if (pmode == 1) bit_out(^d);
    else if (pmode == 2) bit_out(~^d);
    bit_out(stop_v);
    bit_out(1'b1);
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1;
    @(negedge clk);
    s = 1'b0;
    @(negedge clk);
  endtask

  task automatic read_expect(input string req, input logic [7:0] d);
    check(req, "ready before read", rdy, 1);
    check(req, "head data", rdata, d);
    pulse(rd);
  endtask

  task automatic t_reset;
    check("R13", "rx_rdy after reset", rdy, 0);
    check("R13", "full after reset", full, 0);
    check("R13", "overrun after reset", ovr, 0);
    check("R13", "brk_chg after reset", bchg, 0);
    send_char(8'h33, 0, 1'b1);
    check("R11", "nothing stored while disabled from reset", rdy, 0);
  endtask

  task automatic t_basic;
    pulse(c_en);
    send_char(8'hA5, 0, 1'b1);
    check("R7", "data A5", rdata, 8'hA5);
    check("R7", "no frame error", ferr, 0);
    check("R8", "no parity error w/o parity", perr, 0);
    check("R3", "ready set", rdy, 1);
    pulse(rd);
    check("R3", "ready clear after last read", rdy, 0);
    pulse(rd);
    send_char(8'h0F, 0, 1'b1);
    check("R3", "empty read ignored, data", rdata, 8'h0F);
    pulse(rd);
    check("R3", "empty after read", rdy, 0);
    send_char(8'h3C, 0, 1'b0);
    check("R7", "framing error data", rdata, 8'h3C);
    check("R7", "framing error flag", ferr, 1);
    check("R9", "not a break", brk, 0);
    pulse(rd);
  endtask

  task automatic t_parity;
    par_en = 1'b1;
    send_char(8'h96, 1, 1'b1);
    check("R8", "good parity data", rdata, 8'h96);
    check("R8", "good parity flag", perr, 0);
    pulse(rd);
    send_char(8'h96, 2, 1'b1);
    check("R8", "bad parity flag", perr, 1);
    check("R8", "bad parity no frame err", ferr, 0);
    pulse(rd);
    par_en = 1'b0;
  endtask

  task automatic t_false_start;
    rx = 1'b0;
    repeat (3 * TICK_DIV) @(negedge clk);
    rx = 1'b1;
    repeat (12 * BIT_CLK) @(negedge clk);
    check("R6", "glitch stores nothing", rdy, 0);
    send_char(8'h5C, 0, 1'b1);
    read_expect("R6", 8'h5C);
  endtask

  task automatic t_queue;
    send_char(8'h01, 0, 1'b1);
    send_char(8'h02, 0, 1'b1);
    check("R1", "not full at two", full, 0);
    send_char(8'h03, 0, 1'b1);
    check("R1", "full at three", full, 1);
    send_char(8'h04, 0, 1'b1);
    check("R2", "parked char no overrun", ovr, 0);
    read_expect("R1", 8'h01);
    check("R2", "full kept by parked char", full, 1);
    read_expect("R1", 8'h02);
    check("R1", "not full after drain", full, 0);
    read_expect("R1", 8'h03);
    read_expect("R2", 8'h04);
    check("R3", "empty", rdy, 0);
    for (int i = 5; i <= 9; i++) send_char(8'(i), 0, 1'b1);
    check("R4", "overrun set", ovr, 1);
    read_expect("R4", 8'h05);
    read_expect("R4", 8'h06);
    read_expect("R4", 8'h07);
    read_expect("R4", 8'h09);
    check("R4", "fourth char lost", rdy, 0);
    check("R5", "overrun survives reads", ovr, 1);
    pulse(c_rerr);
    check("R5", "overrun cleared by command", ovr, 0);
  endtask

  task automatic t_break;
    brk_pulses = 0;
    rx = 1'b0;
    repeat (14 * BIT_CLK) @(negedge clk);
    check("R10", "one event at break start", brk_pulses, 1);
    check("R9", "break entry flag", brk, 1);
    check("R9", "break entry framing", ferr, 1);
    check("R9", "break entry data", rdata, 0);
    rx = 1'b1;
    repeat (4 * TICK_DIV) @(negedge clk);
    rx = 1'b0;
    repeat (14 * BIT_CLK) @(negedge clk);
    check("R10", "short high does not end break", brk_pulses, 1);
    pulse(rd);
    check("R9", "only one entry for long break", rdy, 0);
    rx = 1'b1;
    repeat (BIT_CLK) @(negedge clk);
    check("R10", "event at break end", brk_pulses, 2);
    send_char(8'h42, 0, 1'b1);
    read_expect("R9", 8'h42);
    check("R9", "normal char after break", brk, 0);
  endtask

  task automatic t_disable;
    send_char(8'h11, 0, 1'b1);
    bit_out(1'b0);
    bit_out(1'b1);
    bit_out(1'b0);
    pulse(c_dis);
    for (int i = 0; i < 6; i++) bit_out(1'b1);
    bit_out(1'b1);
    check("R11", "queue kept on disable", rdata, 8'h11);
    check("R11", "overrun untouched", ovr, 0);
    send_char(8'h77, 0, 1'b1);
    read_expect("R11", 8'h11);
    check("R11", "disabled stored nothing", rdy, 0);
    c_en = 1'b1;
    c_dis = 1'b1;
    @(negedge clk);
    c_en = 1'b0;
    c_dis = 1'b0;
    send_char(8'h66, 0, 1'b1);
    check("R12", "disable wins over enable", rdy, 0);
    pulse(c_en);
    send_char(8'h5A, 0, 1'b1);
    read_expect("R12", 8'h5A);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    rx = 1'b1;
    rd = 1'b0;
    c_en = 1'b0;
    c_dis = 1'b0;
    c_rerr = 1'b0;
    par_en = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_parity();
    t_false_start();
    t_queue();
    t_break();
    t_disable();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule